// File: doc/BRIEF.md
# Raster Interrupt Generator with Deferral

This block raises a periodic active-low interrupt request. It measures time in scan lines from the top of each frame. A line is counted on each rising edge of the horizontal sync input. The first request of a frame comes 18 lines after the frame begins. Each later request follows the previous one by 52 lines, which gives six requests in a frame of a little over 300 lines.

The request stays low until the CPU acknowledge strobe is seen, and it is released on that strobe. If the acknowledge takes more than 26 lines, the schedule slips by 26 lines. That slip carries into every later request of the frame. Between the release of one request and the assertion of the next there are always at least 26 lines. The frame sync input restarts the whole sequence, so the first request always lines up with the top of the frame.

Top module: `raster_irq_gen`

## Requirements
- R1: While reset is held, and on the clock after frame sync is seen high, the request output `intN` is high (inactive). The line count and schedule return to their start state.
- R2: The first request of a frame goes low on the 18th rising edge of `hSync` after frame sync is released.
- R3: When every request is acknowledged 26 or fewer lines after it went low, each request goes low exactly 52 lines after the previous one.
- R4: When a request is acknowledged more than 26 lines after it went low, the next request comes 78 lines after it instead of 52. All later spacing returns to 52 lines from that shifted point.
- R5: Once low, `intN` stays low until `ackStrobe` is sampled high. It is high on the clock after that strobe.
- R6: From an acknowledge to the next request there are at least 26 rising edges of `hSync`. With an acknowledge later than 52 lines, the next request comes exactly 26 lines after the acknowledge.
- R7: An `ackStrobe` pulse while no request is pending has no effect on the schedule.
- R8: Frame sync seen while a request is pending releases it, and the next request follows 18 lines later.
- R9: Lines are counted on rising edges of `hSync` only. A sync pulse held high for several clocks counts as one line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameSync | input | 1 | Active-high frame start; restarts the schedule while high |
| hSync | input | 1 | Horizontal sync; each rising edge is one line |
| ackStrobe | input | 1 | Active-high CPU interrupt acknowledge, one clock or longer |
| intN | output | 1 | Active-low interrupt request |

## Verification
The hardest situations to reach are late acknowledges. One is an acknowledge just past the 26-line limit, which must move the whole remainder of the frame. The other is one so late that the next request falls due while the current one is still pending. Both states take hundreds of clocks of line pulses to reach. The stimulus table sets, for each frame, the acknowledge delay of every request and one request with a different delay. This places the acknowledge exactly at line 26, line 27, line 40 or line 60 of the pending request. The expected request lines are then derived in the bench from the spacing rules. Directed runs add a never-acknowledged request, a frame restart during a pending request, and long sync pulses.

// File: rtl/raster_irq_pkg.sv
package raster_irq_pkg;

  // Strobes issued by the control FSM to the line datapath.
  typedef struct packed {
    logic restart;  // frame start: load first-request distance
    logic fire;     // request asserted this cycle: reload period, clear age
    logic ackLate;  // late acknowledge: push schedule back
    logic pending;  // request outstanding: age counts lines
  } irqStrobes_t;

  typedef enum logic {
    ST_IDLE     = 1'b0,
    ST_ASSERTED = 1'b1
  } irqState_t;

endpackage

// File: rtl/raster_irq_datapath.sv
module raster_irq_datapath
  import raster_irq_pkg::*;
#(
  parameter int FIRST_LINES  = 18,
  parameter int PERIOD_LINES = 52,
  parameter int LATE_LINES   = 26,
  parameter int DEFER_LINES  = 26,
  parameter int CNT_W        = 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hSync,
  input  irqStrobes_t strobes,
  output logic        lineTick,
  output logic        gapDue,
  output logic        ageLate
);

  localparam logic [CNT_W-1:0] FIRST_V  = CNT_W'(FIRST_LINES);
  localparam logic [CNT_W-1:0] PERIOD_V = CNT_W'(PERIOD_LINES);
  localparam logic [CNT_W-1:0] LATE_V   = CNT_W'(LATE_LINES);
  localparam logic [CNT_W-1:0] DEFER_V  = CNT_W'(DEFER_LINES);
  localparam logic [CNT_W-1:0] ONE_V    = CNT_W'(1);
  localparam logic [CNT_W-1:0] AGE_MAX  = {CNT_W{1'b1}};

  logic             hsPrev;
  logic [CNT_W-1:0] gapCnt;
  logic [CNT_W-1:0] gapNext;
  logic [CNT_W-1:0] ageCnt;
  logic [CNT_W-1:0] ageNext;

  // Edge detector: one tick per rising edge of horizontal sync.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) hsPrev <= 1'b0;
    else       hsPrev <= hSync;
  end

  assign lineTick = hSync & ~hsPrev;

  // Lines remaining until the next request. Saturates at zero while a
  // request is still pending, so a very late acknowledge cannot underflow.
  always_comb begin
    gapNext = gapCnt;
    if (strobes.restart) begin
      gapNext = FIRST_V;
    end else if (strobes.fire) begin
      gapNext = PERIOD_V;
    end else begin
      if (lineTick && (gapCnt != '0)) gapNext = gapCnt - ONE_V;
      if (strobes.ackLate)            gapNext = gapNext + DEFER_V;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) gapCnt <= FIRST_V;
    else       gapCnt <= gapNext;
  end

  // Age of the outstanding request in lines.
  always_comb begin
    ageNext = ageCnt;
    if (strobes.restart || strobes.fire)
      ageNext = '0;
    else if (strobes.pending && lineTick && (ageCnt != AGE_MAX))
      ageNext = ageCnt + ONE_V;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ageCnt <= '0;
    else       ageCnt <= ageNext;
  end

  assign gapDue  = (gapCnt <= ONE_V);
  assign ageLate = (ageCnt > LATE_V);

endmodule

// File: rtl/raster_irq_ctrl.sv
module raster_irq_ctrl
  import raster_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameSync,
  input  logic        ackStrobe,
  input  logic        lineTick,
  input  logic        gapDue,
  input  logic        ageLate,
  output irqStrobes_t strobes,
  output logic        intN
);

  irqState_t state;
  irqState_t stateNext;
  logic      ackTaken;

  assign ackTaken = (state == ST_ASSERTED) && ackStrobe && !frameSync;

  always_comb begin
    strobes.restart = frameSync;
    strobes.pending = (state == ST_ASSERTED);
    strobes.fire    = !frameSync && (state == ST_IDLE) && lineTick && gapDue;
    strobes.ackLate = ackTaken && ageLate;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:     if (strobes.fire) stateNext = ST_ASSERTED;
      ST_ASSERTED: if (ackTaken)     stateNext = ST_IDLE;
      default:                       stateNext = ST_IDLE;
    endcase
    if (frameSync) stateNext = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign intN = (state != ST_ASSERTED);

endmodule

// File: rtl/raster_irq_gen.sv
module raster_irq_gen
  import raster_irq_pkg::*;
#(
  parameter int FIRST_LINES  = 18,
  parameter int PERIOD_LINES = 52,
  parameter int LATE_LINES   = 26,
  parameter int DEFER_LINES  = 26,
  parameter int CNT_W        = 10
) (
  input  logic clk,
  input  logic rstN,
  input  logic frameSync,
  input  logic hSync,
  input  logic ackStrobe,
  output logic intN
);

  irqStrobes_t strobes;
  logic        lineTick;
  logic        gapDue;
  logic        ageLate;

  raster_irq_datapath #(
    .FIRST_LINES (FIRST_LINES),
    .PERIOD_LINES(PERIOD_LINES),
    .LATE_LINES  (LATE_LINES),
    .DEFER_LINES (DEFER_LINES),
    .CNT_W       (CNT_W)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .hSync   (hSync),
    .strobes (strobes),
    .lineTick(lineTick),
    .gapDue  (gapDue),
    .ageLate (ageLate)
  );

  raster_irq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .frameSync(frameSync),
    .ackStrobe(ackStrobe),
    .lineTick (lineTick),
    .gapDue   (gapDue),
    .ageLate  (ageLate),
    .strobes  (strobes),
    .intN     (intN)
  );

endmodule

// File: rtl/raster_irq_checker.sv
module raster_irq_checker #(
  parameter int DEFER_LINES = 26
) (
  input logic clk,
  input logic rstN,
  input logic frameSync,
  input logic hSync,
  input logic ackStrobe,
  input logic intN
);

  logic hsD;
  logic released;
  int   linesSinceRel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hsD           <= 1'b0;
      released      <= 1'b0;
      linesSinceRel <= 0;
    end else begin
      hsD <= hSync;
      if (frameSync) begin
        released      <= 1'b0;
        linesSinceRel <= 0;
      end else if (ackStrobe && !intN) begin
        released      <= 1'b1;
        linesSinceRel <= 0;
      end else if (hSync && !hsD) begin
        linesSinceRel <= linesSinceRel + 1;
      end
    end
  end

  // R1: reset holds the request inactive
  always @(posedge clk) begin
    if (!rstN) a_r1_reset_idle: assert (intN);
  end

  // R1, R8: frame sync releases any request
  a_r1_frame_releases: assert property (@(posedge clk) disable iff (!rstN)
    frameSync |=> intN);

  // R5: request held until acknowledge
  a_r5_hold_low: assert property (@(posedge clk) disable iff (!rstN)
    (!intN && !ackStrobe && !frameSync) |=> !intN);

  // R5: release only from acknowledge or frame sync
  a_r5_release_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intN) |-> $past(ackStrobe || frameSync));

  // R5: acknowledge of a pending request releases it
  a_r5_ack_releases: assert property (@(posedge clk) disable iff (!rstN)
    (!intN && ackStrobe) |=> intN);

  // R9: request assertion only on a sync rising edge
  a_r9_fall_on_edge: assert property (@(posedge clk) disable iff (!rstN)
    $fell(intN) |-> ($past(hSync) && !$past(hsD)));

  // R6: minimum spacing from release to next assertion
  a_r6_min_spacing: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(intN) && released) |-> (linesSinceRel >= DEFER_LINES));

endmodule

bind raster_irq_gen raster_irq_checker #(.DEFER_LINES(DEFER_LINES)) u_checker (
  .clk      (clk),
  .rstN     (rstN),
  .frameSync(frameSync),
  .hSync    (hSync),
  .ackStrobe(ackStrobe),
  .intN     (intN)
);

// File: tb/raster_irq_gen_bench.sv
module raster_irq_gen_bench;

  localparam int CLK_PERIOD  = 10;
  localparam int FRAME_LINES = 320;
  localparam int NVEC        = 6;
  localparam int FIRST       = 18;
  localparam int PERIOD      = 52;
  localparam int LATE        = 26;
  localparam int DEFER       = 26;

  // Per frame: {normal ack delay, index of odd request (-1 none), its delay, idle ack at line 5}
  localparam int VEC [NVEC][4] = '{
    '{ 1, -1,  0, 0},
    '{26, -1,  0, 1},
    '{27, -1,  0, 0},
    '{ 5,  1, 40, 0},
    '{10,  0, 60, 0},
    '{26,  2, 27, 0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameSync = 1'b0;
  logic hSync = 1'b0;
  logic ackStrobe = 1'b0;
  logic intN;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  raster_irq_gen u_raster_irq_gen (
    .clk      (clk),
    .rstN     (rstN),
    .frameSync(frameSync),
    .hSync    (hSync),
    .ackStrobe(ackStrobe),
    .intN     (intN)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic oneLine(input int hi);
    @(negedge clk) hSync = 1'b1;
    repeat (hi - 1) @(negedge clk);
    @(negedge clk) hSync = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulseAck();
    @(negedge clk) ackStrobe = 1'b1;
    @(negedge clk) ackStrobe = 1'b0;
  endtask

  task automatic frameStart();
    @(negedge clk) frameSync = 1'b1;
    @(negedge clk) frameSync = 1'b0;
  endtask

  function automatic int delayOf(input int v, input int k);
    return (k == VEC[v][1]) ? VEC[v][2] : VEC[v][0];
  endfunction

  task automatic runVector(input int v);
    int expLine [8];
    int obsLine [8];
    string expTag [8];
    int nExp = 1;
    int nObs = 0;
    int lastFall = 0;
    bit waiting = 1'b0;
    bit sawLate = 1'b0;
    logic prevInt = 1'b1;
    expLine[0] = FIRST;
    expTag[0]  = "R2";
    for (int k = 0; k < 7; k++) begin
      int d = delayOf(v, k);
      int gap = ((PERIOD - d) > 0 ? (PERIOD - d) : 0) + ((d > LATE) ? DEFER : 0);
      int nxt = expLine[k] + d + gap;
      if (d > LATE) sawLate = 1'b1;
      if (nxt > FRAME_LINES) break;
      expLine[k+1] = nxt;
      expTag[k+1]  = (d > PERIOD) ? "R6" : (sawLate ? "R4" : "R3");
      nExp++;
    end
    frameStart();
    check("R1", intN, 1);
    for (int ln = 1; ln <= FRAME_LINES; ln++) begin
      oneLine(2);
      if (VEC[v][3] != 0 && ln == 5) begin
        pulseAck();  // R7: acknowledge while idle
      end
      if (prevInt == 1'b1 && intN == 1'b0) begin
        if (nObs < 8) obsLine[nObs] = ln;
        nObs++;
        lastFall = ln;
        waiting = 1'b1;
      end
      if (waiting && (ln - lastFall) == delayOf(v, nObs - 1)) begin
        check("R5", intN, 0);
        pulseAck();
        check("R5", intN, 1);
        waiting = 1'b0;
      end
      prevInt = intN;
    end
    check((VEC[v][3] != 0) ? "R7" : "R3", nObs, nExp);
    for (int k = 0; k < nExp && k < nObs && k < 8; k++) begin
      check(expTag[k], obsLine[k], expLine[k]);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", intN, 1);
    @(negedge clk) rstN = 1'b1;
    @(negedge clk);
    check("R1", intN, 1);

    // Table-driven frames: R2, R3, R4, R6, R7
    for (int v = 0; v < NVEC; v++) runVector(v);

    // R5: never acknowledged, request stays low
    frameStart();
    for (int ln = 1; ln <= FIRST; ln++) oneLine(2);
    check("R2", intN, 0);
    for (int ln = 0; ln < 100; ln++) oneLine(2);
    check("R5", intN, 0);

    // R8: frame sync during a pending request, then R9 with long sync pulses
    frameStart();
    check("R8", intN, 1);
    for (int ln = 1; ln < FIRST; ln++) oneLine(8);
    check("R9", intN, 1);
    oneLine(8);
    check("R9", intN, 0);

    // R1: reset during a pending request
    @(negedge clk) rstN = 1'b0;
    @(negedge clk);
    check("R1", intN, 1);
    @(negedge clk) rstN = 1'b1;

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule